// File: doc/BRIEF.md
# Graded Power-State Sequencer

This block steers a processing core between four power states of increasing depth: active, doze, nap and sleep. Software or a higher-level manager drives a requested mode on `req_mode`. An asynchronous-to-the-sequence wake event on `wake` pulls the core back to full operation. The block drives six power-control enables: core clock, bus clock, PLL, bus snooping, reduced-voltage select and the core power switch. It also reports the mode it has reached and a `ready` flag.

Shutdown is cumulative and runs as a ladder of six steps, one step per clock. The order is: core clock off, snooping off, bus clock off, PLL off, reduced voltage selected, power switch opened. Doze stops after the first step, nap after the fifth and sleep after the sixth. Wake-up climbs the same ladder in reverse. After each supply-restoring step the block waits `settle_cycles`, and after re-enabling the PLL it waits `lock_cycles` before any clock is ungated. Deeper modes therefore always take longer to leave.

Requests are sampled only while no sequence is running, so a request that changes mid-sequence takes effect once the sequence is done. A wake event interrupts an entry in progress and climbs back from the step already reached.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: One clock after synchronous reset is released, every enable (core clock, bus clock, PLL, snoop, power switch) is 1, `vlow_sel` is 0, `cur_mode` is 0 and `ready` is 1.
- R2: Mode codes on `req_mode`/`cur_mode` are 0 active, 1 doze, 2 nap, 3 sleep. At rest in doze only the core clock is off. In nap the core clock, snoop, bus clock and PLL are off, `vlow_sel` is 1 and the switch is on. In sleep all of those are off, `vlow_sel` is 1 and `pwr_sw_en` is 0.
- R3: Entry changes exactly one control per clock in the order core clock, snoop, bus clock, PLL, `vlow_sel`, power switch. The first step comes two clocks after the request is presented to an idle block.
- R4: Exit reverses that order, again one control per change.
- R5: After `pll_en` rises, the bus clock is re-enabled exactly `lock_cycles`+2 clocks later. No clock enable is 1 while `pll_en` is 0.
- R6: After `pwr_sw_en` rises, or after `vlow_sel` falls, the next step follows exactly `settle_cycles`+2 clocks later, and the controls stay still meanwhile.
- R7: A wake during entry stops the descent on the next clock. The exit then starts from the step already reached and ends in active.
- R8: A change of `req_mode` while a sequence runs does not alter that sequence. The new mode is acted on after the sequence completes.
- R9: `ready` is 1 only when the block is at rest in active with all enables on.
- R10: While `wake` is 1, no entry starts, and a wake in active has no effect on any output.
- R11: From `wake` rising at rest, `ready` returns after 2 clocks from doze, `settle_cycles`+`lock_cycles`+8 from nap, and 2*`settle_cycles`+`lock_cycles`+10 from sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_mode | input | 2 | Requested mode (0 active, 1 doze, 2 nap, 3 sleep) |
| wake | input | 1 | Wake event, returns the core to active |
| settle_cycles | input | CNT_W | Supply settle wait, sampled when the wait starts |
| lock_cycles | input | CNT_W | PLL relock wait, sampled when the wait starts |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_en | output | 1 | Bus-snoop enable |
| vlow_sel | output | 1 | Selects the reduced supply level |
| pwr_sw_en | output | 1 | Core power-switch enable |
| cur_mode | output | 2 | Deepest mode the ladder has reached |
| ready | output | 1 | Core at rest in active with everything on |

## Verification
The hardest situation to reach from the ports is a wake that lands partway down an entry, together with a request that changes while the ladder is moving. The stimulus times both by counting clock edges from the request. It raises `wake` after exactly three edges, so the descent has reached the snoop step. In a separate run it switches `req_mode` three edges into a sleep entry. The scoreboard then expects the precise up-and-down ladder of control vectors. The wait windows are also run with zero counts, so the edge timing of R5 and R6 is checked at its minimum.

// File: rtl/pmc_pkg.sv
// Shared definitions for the graded power-state sequencer.
// Assumes the shutdown ladder has six cumulative steps; a "level" is the
// number of steps currently applied (0 = fully on).
package pmc_pkg;
    localparam int NUM_STEPS = 6;
    localparam int LVL_W     = $clog2(NUM_STEPS + 1);

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_DOZE   = 2'd1,
        MODE_NAP    = 2'd2,
        MODE_SLEEP  = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ENTER,
        SEQ_EXIT,
        SEQ_WAIT
    } seq_st_e;

    // Step positions on the ladder (index = level before the step is applied)
    localparam int STEP_CORE   = 0;
    localparam int STEP_SNOOP  = 1;
    localparam int STEP_BUS    = 2;
    localparam int STEP_PLL    = 3;
    localparam int STEP_VLOW   = 4;
    localparam int STEP_SWITCH = 5;

    localparam lvl_t LVL_ONE     = lvl_t'(1);
    localparam lvl_t LVL_DOZE    = lvl_t'(STEP_CORE + 1);
    localparam lvl_t LVL_PLL_OFF = lvl_t'(STEP_PLL + 1);
    localparam lvl_t LVL_NAP     = lvl_t'(STEP_VLOW + 1);
    localparam lvl_t LVL_SLEEP   = lvl_t'(STEP_SWITCH + 1);

    function automatic lvl_t mode_to_lvl(pmode_e m);
        case (m)
            MODE_DOZE:  return LVL_DOZE;
            MODE_NAP:   return LVL_NAP;
            MODE_SLEEP: return LVL_SLEEP;
            default:    return '0;
        endcase
    endfunction

    function automatic pmode_e lvl_to_mode(lvl_t l);
        if (l >= LVL_SLEEP)     return MODE_SLEEP;
        else if (l >= LVL_NAP)  return MODE_NAP;
        else if (l >= LVL_DOZE) return MODE_DOZE;
        else                    return MODE_ACTIVE;
    endfunction
endpackage

// File: rtl/pmc_wait_timer.sv
// Down-counting wait timer for supply settle and PLL relock windows.
// Assumes start is a one-cycle pulse; done is high in the final busy cycle.
module pmc_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Load on start, then count down to zero and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= load_val;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CNT_ONE;
        end
    end

    // Final cycle of the window
    always_comb done = busy && (cnt == '0);
endmodule

// File: rtl/pmc_step_seq.sv
// Ladder sequencer: walks the shutdown level one step per clock toward the
// target, pausing in WAIT after supply-restore and PLL re-enable steps.
// Assumes req_lvl is only sampled at rest; wake forces the target to zero.
module pmc_step_seq
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_t req_lvl,
    input  logic wake,
    input  logic tmr_done,
    output lvl_t lvl,
    output logic busy,
    output logic tmr_start,
    output logic tmr_use_lock
);
    seq_st_e st;
    lvl_t    tgt;
    lvl_t    tgt_eff;

    // Effective target and wait-timer launch decode
    always_comb begin
        tgt_eff      = wake ? '0 : tgt;
        tmr_start    = (st == SEQ_EXIT) && (lvl >= LVL_PLL_OFF);
        tmr_use_lock = (lvl == LVL_PLL_OFF);
        busy         = (st != SEQ_IDLE);
    end

    // Sequencer state, level and target registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SEQ_IDLE;
            lvl <= '0;
            tgt <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (wake) begin
                        tgt <= '0;
                        if (lvl != '0) st <= SEQ_EXIT;
                    end else if (req_lvl > lvl) begin
                        tgt <= req_lvl;
                        st  <= SEQ_ENTER;
                    end else if (req_lvl < lvl) begin
                        tgt <= req_lvl;
                        st  <= SEQ_EXIT;
                    end
                end
                SEQ_ENTER: begin
                    if (wake) begin
                        tgt <= '0;
                        st  <= (lvl == '0) ? SEQ_IDLE : SEQ_EXIT;
                    end else begin
                        lvl <= lvl + LVL_ONE;
                        if (lvl + LVL_ONE == tgt) st <= SEQ_IDLE;
                    end
                end
                SEQ_EXIT: begin
                    tgt <= tgt_eff;
                    if (lvl == '0) begin
                        st <= SEQ_IDLE;
                    end else begin
                        lvl <= lvl - LVL_ONE;
                        if (tmr_start)                   st <= SEQ_WAIT;
                        else if (lvl - LVL_ONE == tgt_eff) st <= SEQ_IDLE;
                    end
                end
                SEQ_WAIT: begin
                    tgt <= tgt_eff;
                    if (tmr_done) st <= (lvl == tgt_eff) ? SEQ_IDLE : SEQ_EXIT;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == $past(lvl)) || (lvl == $past(lvl) + LVL_ONE) || ($past(lvl) == lvl + LVL_ONE)); // R3
    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LVL_SLEEP); // R4
endmodule

// File: rtl/pmc_out_decode.sv
// Turns the ladder level into the six power controls and status outputs.
// Assumes a step is applied when the level exceeds its ladder index.
module pmc_out_decode
    import pmc_pkg::*;
(
    input  lvl_t       lvl,
    input  logic       busy,
    output logic       core_clk_en,
    output logic       bus_clk_en,
    output logic       pll_en,
    output logic       snoop_en,
    output logic       vlow_sel,
    output logic       pwr_sw_en,
    output logic [1:0] cur_mode,
    output logic       ready
);
    logic [NUM_STEPS-1:0] applied;

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        assign applied[i] = (lvl > lvl_t'(i));
    end

    // Map applied steps onto the individual controls and status
    always_comb begin
        core_clk_en = !applied[STEP_CORE];
        snoop_en    = !applied[STEP_SNOOP];
        bus_clk_en  = !applied[STEP_BUS];
        pll_en      = !applied[STEP_PLL];
        vlow_sel    =  applied[STEP_VLOW];
        pwr_sw_en   = !applied[STEP_SWITCH];
        cur_mode    = lvl_to_mode(lvl);
        ready       = (applied == '0) && !busy;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Graded power-state controller top: sequencer, wait timer, output decode.
// Assumes settle_cycles and lock_cycles are stable when a wait begins.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_mode,
    input  logic             wake,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic [CNT_W-1:0] lock_cycles,
    output logic             core_clk_en,
    output logic             bus_clk_en,
    output logic             pll_en,
    output logic             snoop_en,
    output logic             vlow_sel,
    output logic             pwr_sw_en,
    output logic [1:0]       cur_mode,
    output logic             ready
);
    lvl_t             lvl;
    lvl_t             req_lvl;
    logic             seq_busy;
    logic             tmr_start;
    logic             tmr_use_lock;
    logic             tmr_busy;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    // Requested level and wait-window length selection
    always_comb begin
        req_lvl = mode_to_lvl(pmode_e'(req_mode));
        tmr_val = tmr_use_lock ? lock_cycles : settle_cycles;
    end

    pmc_step_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_lvl      (req_lvl),
        .wake         (wake),
        .tmr_done     (tmr_done),
        .lvl          (lvl),
        .busy         (seq_busy),
        .tmr_start    (tmr_start),
        .tmr_use_lock (tmr_use_lock)
    );

    pmc_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .load_val (tmr_val),
        .busy     (tmr_busy),
        .done     (tmr_done)
    );

    pmc_out_decode u_dec (
        .lvl         (lvl),
        .busy        (seq_busy),
        .core_clk_en (core_clk_en),
        .bus_clk_en  (bus_clk_en),
        .pll_en      (pll_en),
        .snoop_en    (snoop_en),
        .vlow_sel    (vlow_sel),
        .pwr_sw_en   (pwr_sw_en),
        .cur_mode    (cur_mode),
        .ready       (ready)
    );

    AST_LOCK_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> (!bus_clk_en && !core_clk_en && !snoop_en)); // R5
    AST_SUPPLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_sw_en |-> (vlow_sel && !pll_en)); // R3
    AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |=> $stable({core_clk_en, snoop_en, bus_clk_en, pll_en, vlow_sel, pwr_sw_en})); // R6
    AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (core_clk_en && bus_clk_en && pll_en && snoop_en && pwr_sw_en && !vlow_sel
                   && cur_mode == 2'd0)); // R9
    AST_WAKE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wake) |=> ready); // R10
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue the expected control vectors of each ladder
// walk; a negedge monitor pops one per observed change and compares.
module tb_pwr_mode_ctrl;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       req_mode;
    logic             wake;
    logic [CNT_W-1:0] settle_cycles;
    logic [CNT_W-1:0] lock_cycles;
    logic core_clk_en, bus_clk_en, pll_en, snoop_en, vlow_sel, pwr_sw_en, ready;
    logic [1:0] cur_mode;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .wake(wake),
        .settle_cycles(settle_cycles), .lock_cycles(lock_cycles),
        .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .pll_en(pll_en),
        .snoop_en(snoop_en), .vlow_sel(vlow_sel), .pwr_sw_en(pwr_sw_en),
        .cur_mode(cur_mode), .ready(ready)
    );

    // {core, snoop, bus, pll, vlow, switch}
    logic [5:0] vec;
    assign vec = {core_clk_en, snoop_en, bus_clk_en, pll_en, vlow_sel, pwr_sw_en};

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit mon_on = 0;
    bit finished = 0;
    logic [5:0] prev;
    logic [5:0] exp_q[$];
    string      tag_q[$];
    int t_pll_rise, t_bus_rise, t_sw_rise, t_vlow_fall;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] vec_of(int l);
        return {l < 1, l < 2, l < 3, l < 4, l >= 5, l < 6};
    endfunction

    // Driver side: queue every intermediate level from 'from' to 'to'
    task automatic push_path(int from, int to, string tag);
        if (to > from) for (int l = from + 1; l <= to; l++) begin exp_q.push_back(vec_of(l)); tag_q.push_back(tag); end
        else           for (int l = from - 1; l >= to; l--) begin exp_q.push_back(vec_of(l)); tag_q.push_back(tag); end
    endtask

    // Monitor: compare each control change against the scoreboard
    always @(negedge clk) begin
        if (mon_on && vec !== prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R4 unexpected change", int'(vec), int'(prev));
            end else begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(vec === e, t, int'(vec), int'(e));
            end
            if (pll_en && !prev[2])    t_pll_rise  = cyc;
            if (bus_clk_en && !prev[3]) t_bus_rise = cyc;
            if (pwr_sw_en && !prev[0]) t_sw_rise   = cyc;
            if (!vlow_sel && prev[1])  t_vlow_fall = cyc;
            prev = vec;
        end
    end

    task automatic drain(string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 400) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic wake_latency(output int n);
        n = 0;
        wake = 1'b1;
        req_mode = 2'd0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!ready && n < 500);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; req_mode = 2'd0; wake = 1'b0;
        settle_cycles = 8'd3; lock_cycles = 8'd5;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R9 ready at rest
        chk(vec === 6'b111101, "R1 reset controls", int'(vec), 6'b111101);
        chk(cur_mode === 2'd0, "R1 reset mode", int'(cur_mode), 0);
        chk(ready === 1'b1, "R9 ready after reset", int'(ready), 1);
        prev = vec; mon_on = 1;

        // R2/R3 doze entry
        push_path(0, 1, "R3 doze entry");
        req_mode = 2'd1;
        drain("R3 doze drain");
        chk(cur_mode === 2'd1, "R2 doze mode", int'(cur_mode), 1);
        chk(ready === 1'b0, "R9 not ready in doze", int'(ready), 0);

        // R4 exit by request
        push_path(1, 0, "R4 doze exit");
        req_mode = 2'd0;
        drain("R4 doze exit drain");
        chk(ready === 1'b1, "R9 ready after exit", int'(ready), 1);

        // R2/R3 nap entry
        push_path(0, 5, "R3 nap entry");
        req_mode = 2'd2;
        drain("R3 nap drain");
        chk(cur_mode === 2'd2, "R2 nap mode", int'(cur_mode), 2);
        chk(vec === vec_of(5), "R2 nap controls", int'(vec), int'(vec_of(5)));

        // R11/R5/R6 wake from nap, settle 3, lock 5
        push_path(5, 0, "R4 nap exit");
        wake_latency(n);
        chk(n == 16, "R11 nap wake latency", n, 16);
        chk(t_bus_rise - t_pll_rise == 7, "R5 lock gap", t_bus_rise - t_pll_rise, 7);
        chk(t_pll_rise - t_vlow_fall == 5, "R6 settle gap nap", t_pll_rise - t_vlow_fall, 5);
        wake = 1'b0;
        drain("R4 nap exit drain");

        // R2 sleep entry, then R11/R6 wake from sleep, settle 2, lock 4
        settle_cycles = 8'd2; lock_cycles = 8'd4;
        push_path(0, 6, "R3 sleep entry");
        req_mode = 2'd3;
        drain("R3 sleep drain");
        chk(cur_mode === 2'd3, "R2 sleep mode", int'(cur_mode), 3);
        chk(vec === vec_of(6), "R2 sleep controls", int'(vec), int'(vec_of(6)));
        push_path(6, 0, "R4 sleep exit");
        wake_latency(n);
        chk(n == 18, "R11 sleep wake latency", n, 18);
        chk(t_vlow_fall - t_sw_rise == 4, "R6 settle gap switch", t_vlow_fall - t_sw_rise, 4);
        chk(t_bus_rise - t_pll_rise == 6, "R5 lock gap sleep", t_bus_rise - t_pll_rise, 6);
        wake = 1'b0;
        drain("R4 sleep exit drain");

        // R8 request changed mid-entry is held until the entry completes
        push_path(0, 6, "R8 held entry");
        push_path(6, 1, "R8 deferred request");
        req_mode = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk) req_mode = 2'd1;
        drain("R8 drain");
        chk(cur_mode === 2'd1, "R8 final mode", int'(cur_mode), 1);
        push_path(1, 0, "R4 doze exit");
        req_mode = 2'd0;
        drain("R4 drain 2");

        // R7 wake aborts entry at the snoop step; R10 wake blocks re-entry
        exp_q.push_back(vec_of(1)); tag_q.push_back("R7 abort step1");
        exp_q.push_back(vec_of(2)); tag_q.push_back("R7 abort step2");
        exp_q.push_back(vec_of(1)); tag_q.push_back("R7 climb back");
        exp_q.push_back(vec_of(0)); tag_q.push_back("R7 active again");
        req_mode = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk) wake = 1'b1;
        drain("R7 drain");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ready === 1'b1, "R10 wake blocks entry", int'(ready), 1);
        end
        req_mode = 2'd0;
        repeat (3) @(negedge clk);
        chk(vec === vec_of(0), "R10 wake in active no effect", int'(vec), int'(vec_of(0)));
        wake = 1'b0;
        @(negedge clk);

        // R11 doze latency
        push_path(0, 1, "R3 doze entry 2");
        req_mode = 2'd1;
        drain("R3 doze drain 2");
        push_path(1, 0, "R4 doze wake exit");
        wake_latency(n);
        chk(n == 2, "R11 doze wake latency", n, 2);
        wake = 1'b0;
        drain("R4 doze wake drain");

        // R11/R5/R6 zero-length windows from sleep
        settle_cycles = 8'd0; lock_cycles = 8'd0;
        push_path(0, 6, "R3 sleep entry 2");
        req_mode = 2'd3;
        drain("R3 sleep drain 2");
        push_path(6, 0, "R4 sleep exit 2");
        wake_latency(n);
        chk(n == 10, "R11 sleep zero-count latency", n, 10);
        chk(t_bus_rise - t_pll_rise == 2, "R5 zero lock gap", t_bus_rise - t_pll_rise, 2);
        chk(t_vlow_fall - t_sw_rise == 2, "R6 zero settle gap", t_vlow_fall - t_sw_rise, 2);
        wake = 1'b0;
        drain("R4 sleep exit drain 2");
        chk(ready === 1'b1, "R9 ready at end", int'(ready), 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule